// File: doc/BRIEF.md
# Output Driver Impedance Drift Tracker

This block holds the two drive-strength codes of an output driver, one for the pull-up half and one for the pull-down half. Each code selects a set of binary-weighted impedance legs. Supply voltage and temperature drift over time, so the codes have to follow a target code that an external comparator supplies. A free-running cycle timer starts an evaluation at a fixed interval. At each evaluation, each code is moved at most one step toward its target.

A half of the driver must not change strength while it is actively driving. For that reason a computed step is first stored as a pending update. It is written to the active code only in a cycle where that half is idle. The pull-down half is idle when the pad drives a high level or is tri-stated. The pull-up half is idle when the pad drives a low level or is tri-stated. The two codes are registered outputs that go straight to the leg-enable logic.

Top module: `zq_drift_tracker`

## Requirements
- R1: After reset both codes equal mid-scale, which is 100000 binary (32) for the default 6-bit width. No pending update exists after reset.
- R2: The cycle timer counts 0 to PERIOD-1, wraps to 0, and raises an evaluation in the cycle when it holds PERIOD-1. The first evaluation takes effect at the PERIOD-th rising edge after reset is released.
- R3: An evaluation computes a new code that is the active code plus one when the target is larger, and minus one when the target is smaller.
- R4: When the target equals the active code, the evaluation leaves the code unchanged and discards any pending step.
- R5: The pull-down code changes only on an edge where, in that cycle, `drv_hiz`=1 or `drv_val`=1.
- R6: The pull-up code changes only on an edge where, in that cycle, `drv_hiz`=1 or `drv_val`=0.
- R7: A pending step is applied exactly once, on the first edge after the evaluation at which its half is idle. If an evaluation and a safe cycle fall on the same edge, the evaluation takes priority.
- R8: Codes saturate at all-zeros and all-ones and never wrap.
- R9: A new evaluation replaces a step that is still pending with a step computed from the active code. The active code therefore never moves more than one unit per evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_pu | input | CODE_W | Target pull-up code from the comparator |
| tgt_pd | input | CODE_W | Target pull-down code from the comparator |
| drv_val | input | 1 | Data value the driver is producing |
| drv_hiz | input | 1 | Driver is tri-stated |
| pu_code | output | CODE_W | Active pull-up leg code |
| pd_code | output | CODE_W | Active pull-down leg code |

## Verification
A wrong timer phase moves the code changes to the wrong edge, and a per-cycle compare catches this at the first evaluation, PERIOD cycles after reset. A lost or duplicated pending step leaves a code one unit off. This shows on the edge where the driver next becomes idle, and it persists until the next evaluation. A wrong safety decode shows as a code change while the driver holds that half active, on the very cycle of the change.

// File: rtl/zq_pkg.sv
package zq_pkg;
  typedef enum logic {HALF_PULLUP = 1'b0, HALF_PULLDOWN = 1'b1} half_kind_e;
endpackage

// File: rtl/zq_period_timer.sv
module zq_period_timer #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic eval_tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign eval_tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (eval_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R2: the count stays within the period
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
  // R2: after the terminal count the timer restarts at zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst) eval_tick |=> (cnt_q == '0));
endmodule

// File: rtl/zq_half_tracker.sv
module zq_half_tracker
  import zq_pkg::*;
#(
  parameter int         CODE_W = 6,
  parameter half_kind_e KIND   = HALF_PULLUP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_tick,
  input  logic [CODE_W-1:0] target,
  input  logic              drv_val,
  input  logic              drv_hiz,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP  = '1;

  logic              idle;
  logic [CODE_W-1:0] next_code;
  logic [CODE_W-1:0] pend_code;
  logic              pend_vld;

  generate
    if (KIND == HALF_PULLUP) begin : g_pu
      assign idle = drv_hiz | ~drv_val;
    end else begin : g_pd
      assign idle = drv_hiz | drv_val;
    end
  endgenerate

  always_comb begin
    next_code = code;
    if (target > code && code != TOP)       next_code = code + 1'b1;
    else if (target < code && code != '0)   next_code = code - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= MID;
      pend_code <= MID;
      pend_vld  <= 1'b0;
    end else if (eval_tick) begin
      pend_code <= next_code;
      pend_vld  <= (next_code != code);
    end else if (pend_vld && idle) begin
      code     <= pend_code;
      pend_vld <= 1'b0;
    end
  end

  // R5/R6: the code changes only after a cycle in which this half was idle
  a_r5_r6_safe_change: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> ($past(idle) && $past(pend_vld)));
  // R3/R9: at most one unit per change
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> ((code == $past(code) + 1'b1) || (code == $past(code) - 1'b1)));
  // R7: an applied step is consumed
  a_r7_apply_once: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && idle && !eval_tick) |=> !pend_vld);
  // R8: no wrap across the ends of the range
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !(($past(code) == TOP && code == '0) || ($past(code) == '0 && code == TOP)));
endmodule

// File: rtl/zq_drift_tracker.sv
module zq_drift_tracker
  import zq_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] tgt_pu,
  input  logic [CODE_W-1:0] tgt_pd,
  input  logic              drv_val,
  input  logic              drv_hiz,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code
);
  logic eval_tick;

  zq_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .eval_tick(eval_tick)
  );

  zq_half_tracker #(.CODE_W(CODE_W), .KIND(HALF_PULLUP)) u_pu (
    .clk(clk), .rst(rst), .eval_tick(eval_tick), .target(tgt_pu),
    .drv_val(drv_val), .drv_hiz(drv_hiz), .code(pu_code)
  );

  zq_half_tracker #(.CODE_W(CODE_W), .KIND(HALF_PULLDOWN)) u_pd (
    .clk(clk), .rst(rst), .eval_tick(eval_tick), .target(tgt_pd),
    .drv_val(drv_val), .drv_hiz(drv_hiz), .code(pd_code)
  );

  // R1: mid-scale codes right after reset
  a_r1_reset_mid: assert property (@(posedge clk)
    rst |=> (pu_code == (CODE_W'(1) << (CODE_W - 1)) && pd_code == (CODE_W'(1) << (CODE_W - 1))));
endmodule

// File: tb/zq_drift_tracker_tb_top.sv
module zq_drift_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 6;
  localparam int PER = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] tgt_pu = '0, tgt_pd = '0;
  logic          drv_val = 1'b0, drv_hiz = 1'b1;
  logic [CW-1:0] pu_code, pd_code;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  // reference model state
  int m_cnt, m_pu, m_pd, m_ppu, m_ppd;
  bit m_vpu, m_vpd;

  always #(CLK_PERIOD/2) clk = ~clk;

  zq_drift_tracker #(.CODE_W(CW), .PERIOD(PER)) dut_i (
    .clk(clk), .rst(rst), .tgt_pu(tgt_pu), .tgt_pd(tgt_pd),
    .drv_val(drv_val), .drv_hiz(drv_hiz), .pu_code(pu_code), .pd_code(pd_code)
  );

  function automatic int toward(int c, int t);
    if (t > c && c < 63) return c + 1;
    if (t < c && c > 0)  return c - 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pu = 32; m_pd = 32; m_vpu = 0; m_vpd = 0; m_ppu = 32; m_ppd = 32;
    end else begin
      bit tick;
      tick = (m_cnt == PER - 1);
      m_cnt = tick ? 0 : m_cnt + 1;
      if (tick) begin
        m_ppu = toward(m_pu, int'(tgt_pu)); m_vpu = (m_ppu != m_pu);
        m_ppd = toward(m_pd, int'(tgt_pd)); m_vpd = (m_ppd != m_pd);
      end else begin
        if (m_vpu && (drv_hiz || !drv_val)) begin m_pu = m_ppu; m_vpu = 0; end
        if (m_vpd && (drv_hiz ||  drv_val)) begin m_pd = m_ppd; m_vpd = 0; end
      end
    end
  end

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // compare on every falling edge once reset is done
  always @(negedge clk) if (!rst) begin
    check({tag, " pu_code"}, int'(pu_code), m_pu);
    check({tag, " pd_code"}, int'(pd_code), m_pd);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset pu", int'(pu_code), 32);
    check("R1 reset pd", int'(pd_code), 32);

    // R2 R3: tri-stated, both halves free to follow
    tag = "R2 R3"; tgt_pu = 40; tgt_pd = 20; drv_hiz = 1;
    run(PER - 2);
    check("R2 no change before first evaluation", int'(pu_code), 32);
    run(3);
    check("R2 R3 first step pu", int'(pu_code), 33);
    check("R2 R3 first step pd", int'(pd_code), 31);
    run(5 * PER);

    // R5 R6: driving high, pull-up blocked, pull-down follows
    tag = "R6 R7"; drv_hiz = 0; drv_val = 1;
    held = int'(pu_code);
    run(4 * PER);
    check("R6 pu held while driving high", int'(pu_code), held);
    tag = "R7"; drv_val = 0; run(2);
    check("R7 single pending applied once", int'(pu_code), held + 1);
    tag = "R5"; run(3 * PER);

    // R4: targets equal to active codes
    tag = "R4"; drv_hiz = 1; tgt_pu = pu_code; tgt_pd = pd_code;
    held = int'(pu_code);
    run(3 * PER);
    check("R4 equal target keeps pu", int'(pu_code), held);

    // R9: pending replaced by a later evaluation
    tag = "R9"; drv_hiz = 0; drv_val = 1; tgt_pu = 0;
    run(PER); tgt_pu = 63; run(PER);
    drv_val = 0; run(2 * PER);

    // R8: saturation at both ends
    tag = "R8"; drv_hiz = 1; tgt_pu = 63; tgt_pd = 0;
    run(40 * PER);
    check("R8 pu saturates high", int'(pu_code), 63);
    check("R8 pd saturates low", int'(pd_code), 0);

    // mixed driver activity and moving targets
    tag = "R3 R5 R6 R7 R9";
    for (int i = 0; i < 600; i++) begin
      drv_hiz = ($urandom_range(0, 3) == 0);
      drv_val = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) begin
        tgt_pu = CW'($urandom_range(0, 63));
        tgt_pd = CW'($urandom_range(0, 63));
      end
      @(negedge clk);
    end

    // R1 again: reset mid-run
    rst = 1; run(2); rst = 0; @(negedge clk);
    check("R1 re-reset pu", int'(pu_code), 32);
    check("R1 re-reset pd", int'(pd_code), 32);
    finish_up();
  end
endmodule